// File: doc/BRIEF.md
# Windowed Bandwidth Zone Monitor

This block sits beside a bus link and measures how much data crosses it. Each accepted beat carries a byte count. The bytes are summed in coarse count units of 64 KiB, and any part of a unit left over carries into the next beat. The sum is taken over a sampling window whose length is a number of pulses of a reference tick (19.2 MHz in the intended system). When a window closes, the unit count is compared against three programmable thresholds and placed in one of four zones. The byte accumulator then restarts from zero.

Each zone hit applies a programmable set of actions to four 8-bit zone event counters. An action can increment a counter, clear it, or both. A zone whose counter is incremented up to its programmed repeat limit latches a local status bit. Local status bits feed a global interrupt layer through per-zone enables. The block also keeps the largest window count seen in each zone, and the most recent window count.

All configuration and observation goes through a simple single-cycle register port. Control software uses the zone interrupts to raise or lower a bandwidth vote.

Top module: `bw_zone_mon`

## Requirements
- R1: Beat byte counts are summed into units of 2^UNIT_LG bytes (default 65536), and a remainder smaller than one unit carries to later beats of the same window. At each window boundary both the unit count and the remainder reset to zero. The count of a closed window is readable at address 14.
- R2: While enabled (address 0, bit 0), a window closes on the W-th tick pulse after the previous boundary, where W is the 20-bit value at address 2. W = 0 never closes a window. While the monitor is disabled, beats and ticks are ignored.
- R3: A closed window's count c falls in zone 3 if c >= high (address 5), else zone 2 if c >= mid (address 4), else zone 1 if c >= low (address 3), else zone 0. A count equal to a threshold belongs to the higher zone.
- R4: The actions register (address 6) holds an 8-bit field for each hit zone z at bits 8*z. Within that field, bits 2*t+1 and 2*t act on the counter of target zone t: the upper bit increments it and the lower bit clears it. With both bits set, the counter ends at 1. Counters saturate at 255 and are readable at addresses 20 to 23.
- R5: After reset, the actions register reads 0x95250901. This value means that a zone-z hit increments zone z and clears all lower zones, and that a zone-0 hit only clears zone 0. The repeat register reads 0xFFFFFFFF after reset.
- R6: The repeat register (address 7) holds an 8-bit limit for zone z at bits 8*z. Local status bit 4+z (address 8) sets when zone z's counter is incremented to a value at or above its limit. A limit of 0xFF never sets it.
- R7: Local status latches whatever the local enable (address 10, bits 7:4) holds. Writing 1s to address 9 at bits 7:4 clears those status bits.
- R8: Global status (address 11, bit 0) sets whenever any local status bit is both set and enabled. A write of bit 0 to address 12 clears global status only if no enabled local status is pending. irq_o is global status gated by the global enable (address 13, bit 0).
- R9: Each zone keeps a peak register (addresses 16 to 19) holding the largest window count classified into that zone.
- R10: Writing bit 0 to address 1 resets the unit count, the remainder, the tick position, the zone counters and the peak registers.
- R11: After reset, status, global status and irq_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Reference tick pulse, one cycle wide |
| beat_vld_i | input | 1 | Beat transferred on the link this cycle |
| beat_bytes_i | input | BEAT_W | Bytes carried by the beat |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |
| irq_o | output | 1 | Global interrupt |

## Verification
The windows are filled with whole-unit beats whose counts land exactly on each threshold and just inside each zone. This separates an inclusive threshold compare from an exclusive one and shows that the zone order is correct. Half-unit beats tell apart a remainder that carries within a window from one that leaks across a boundary. The default and a custom action word are both run, so a swapped increment/clear bit or a wrong field offset shows up in the readable zone counters. Windows are also run with the monitor disabled, with a zero length, after a mid-window clear, and with a muted or disabled zone, and each of these cases must leave an observable register unchanged.

// File: rtl/bzm_pkg.sv
package bzm_pkg;
  localparam int ZONES  = 4;
  localparam int EVT_W  = 8;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] A_CMD   = 5'd1;
  localparam logic [ADDR_W-1:0] A_WIN   = 5'd2;
  localparam logic [ADDR_W-1:0] A_TLO   = 5'd3;
  localparam logic [ADDR_W-1:0] A_TMID  = 5'd4;
  localparam logic [ADDR_W-1:0] A_THI   = 5'd5;
  localparam logic [ADDR_W-1:0] A_ACT   = 5'd6;
  localparam logic [ADDR_W-1:0] A_RPT   = 5'd7;
  localparam logic [ADDR_W-1:0] A_LST   = 5'd8;
  localparam logic [ADDR_W-1:0] A_LCLR  = 5'd9;
  localparam logic [ADDR_W-1:0] A_LEN   = 5'd10;
  localparam logic [ADDR_W-1:0] A_GST   = 5'd11;
  localparam logic [ADDR_W-1:0] A_GCLR  = 5'd12;
  localparam logic [ADDR_W-1:0] A_GEN   = 5'd13;
  localparam logic [ADDR_W-1:0] A_LAST  = 5'd14;
  localparam logic [ADDR_W-1:0] A_PEAK0 = 5'd16;
  localparam logic [ADDR_W-1:0] A_EVT0  = 5'd20;

  // zone z hit: bump zone z, wipe every lower zone; zone 0 wipes itself
  function automatic logic [31:0] dflt_actions();
    logic [31:0] v;
    v = '0;
    for (int z = 0; z < ZONES; z++) begin
      if (z == 0) v[0] = 1'b1;
      else begin
        v[8*z + 2*z + 1] = 1'b1;
        for (int t = 0; t < z; t++) v[8*z + 2*t] = 1'b1;
      end
    end
    return v;
  endfunction
endpackage

// File: rtl/bzm_window_acc.sv
module bzm_window_acc #(
  parameter int BEAT_W  = 20,
  parameter int UNIT_LG = 16,
  parameter int CNT_W   = 32,
  parameter int WIN_W   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic              beat_vld_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  output logic              eval_o,
  output logic [CNT_W-1:0]  win_cnt_o,
  output logic [CNT_W-1:0]  acc_o
);
  localparam int SUM_W = ((BEAT_W > UNIT_LG) ? BEAT_W : UNIT_LG) + 1;

  logic [UNIT_LG-1:0] rem_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WIN_W-1:0]   tick_q;
  logic [SUM_W-1:0]   sum_w;
  logic [CNT_W-1:0]   add_w;
  logic [CNT_W-1:0]   cnt_nxt;
  logic [UNIT_LG-1:0] rem_nxt;

  always_comb begin
    sum_w   = SUM_W'(rem_q) + SUM_W'(beat_bytes_i);
    add_w   = beat_vld_i ? CNT_W'(sum_w >> UNIT_LG) : '0;
    rem_nxt = beat_vld_i ? sum_w[UNIT_LG-1:0] : rem_q;
    cnt_nxt = cnt_q + add_w;
  end

  assign eval_o    = en_i && tick_i && (win_len_i != '0) && (tick_q == win_len_i - 1'b1);
  assign win_cnt_o = cnt_nxt;
  assign acc_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      tick_q <= '0;
    end else if (clr_i) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      tick_q <= '0;
    end else if (en_i) begin
      if (eval_o) begin
        rem_q  <= '0;
        cnt_q  <= '0;
        tick_q <= '0;
      end else begin
        rem_q <= rem_nxt;
        cnt_q <= cnt_nxt;
        if (tick_i) tick_q <= tick_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bzm_zone_eval.sv
module bzm_zone_eval
  import bzm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        eval_i,
  input  logic [CNT_W-1:0]            win_cnt_i,
  input  logic [CNT_W-1:0]            thr_lo_i,
  input  logic [CNT_W-1:0]            thr_mid_i,
  input  logic [CNT_W-1:0]            thr_hi_i,
  input  logic [31:0]                 act_i,
  input  logic [31:0]                 rpt_i,
  input  logic                        clr_i,
  input  logic [ZONES-1:0]            st_clr_i,
  output logic [1:0]                  zone_o,
  output logic [ZONES-1:0][EVT_W-1:0] evt_o,
  output logic [ZONES-1:0][CNT_W-1:0] peak_o,
  output logic [ZONES-1:0]            status_o,
  output logic [CNT_W-1:0]            last_o
);
  logic [1:0]             zone_w;
  logic [7:0]             fld_w;
  logic [ZONES-1:0]       hit_w;
  logic [ZONES-1:0][EVT_W-1:0] evt_q, evt_nxt;
  logic [ZONES-1:0][CNT_W-1:0] peak_q;
  logic [ZONES-1:0]       st_q;
  logic [CNT_W-1:0]       last_q;

  always_comb begin
    if (win_cnt_i >= thr_hi_i)       zone_w = 2'd3;
    else if (win_cnt_i >= thr_mid_i) zone_w = 2'd2;
    else if (win_cnt_i >= thr_lo_i)  zone_w = 2'd1;
    else                             zone_w = 2'd0;
    fld_w = act_i[{zone_w, 3'b000} +: 8];
  end

  for (genvar t = 0; t < ZONES; t++) begin : g_zone
    logic       inc_w, clr_w;
    logic [EVT_W-1:0] base_w, lim_w;
    assign inc_w  = fld_w[2*t+1];
    assign clr_w  = fld_w[2*t];
    assign lim_w  = rpt_i[8*t +: 8];
    assign base_w = clr_w ? '0 : evt_q[t];
    always_comb begin
      evt_nxt[t] = base_w;
      if (inc_w && base_w != '1) evt_nxt[t] = base_w + 1'b1;
    end
    assign hit_w[t] = eval_i && inc_w && (evt_nxt[t] >= lim_w) && (lim_w != 8'hFF);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        evt_q[t]  <= '0;
        peak_q[t] <= '0;
        st_q[t]   <= 1'b0;
      end else begin
        st_q[t] <= (st_q[t] & ~st_clr_i[t]) | hit_w[t];
        if (clr_i) begin
          evt_q[t]  <= '0;
          peak_q[t] <= '0;
        end else if (eval_i) begin
          evt_q[t] <= evt_nxt[t];
          if (zone_w == 2'(t) && win_cnt_i > peak_q[t]) peak_q[t] <= win_cnt_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     last_q <= '0;
    else if (eval_i) last_q <= win_cnt_i;
  end

  assign zone_o   = zone_w;
  assign evt_o    = evt_q;
  assign peak_o   = peak_q;
  assign status_o = st_q;
  assign last_o   = last_q;
endmodule

// File: rtl/bw_zone_mon.sv
module bw_zone_mon
  import bzm_pkg::*;
#(
  parameter int BEAT_W  = 20,
  parameter int UNIT_LG = 16,
  parameter int CNT_W   = 32,
  parameter int WIN_W   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              beat_vld_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  input  logic              reg_wr_i,
  input  logic [4:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  logic             en_q, gen_q, gst_q;
  logic [WIN_W-1:0] win_q;
  logic [CNT_W-1:0] tlo_q, tmid_q, thi_q;
  logic [31:0]      act_q, rpt_q;
  logic [ZONES-1:0] len_q;

  logic             clr_cmd, gclr_w, eval_w, loc_pend;
  logic [ZONES-1:0] lclr_w;
  logic [CNT_W-1:0] win_cnt_w, acc_w, last_w;
  logic [1:0]       zone_w;
  logic [ZONES-1:0][EVT_W-1:0] evt_w;
  logic [ZONES-1:0][CNT_W-1:0] peak_w;
  logic [ZONES-1:0] st_w;

  assign clr_cmd = reg_wr_i && reg_addr_i == A_CMD  && reg_wdata_i[0];
  assign gclr_w  = reg_wr_i && reg_addr_i == A_GCLR && reg_wdata_i[0];
  assign lclr_w  = (reg_wr_i && reg_addr_i == A_LCLR) ? reg_wdata_i[7:4] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      gen_q  <= 1'b0;
      win_q  <= '0;
      tlo_q  <= '0;
      tmid_q <= '0;
      thi_q  <= '0;
      act_q  <= dflt_actions();
      rpt_q  <= '1;
      len_q  <= '0;
    end else if (reg_wr_i) begin
      case (reg_addr_i)
        A_CTRL: en_q   <= reg_wdata_i[0];
        A_WIN:  win_q  <= reg_wdata_i[WIN_W-1:0];
        A_TLO:  tlo_q  <= CNT_W'(reg_wdata_i);
        A_TMID: tmid_q <= CNT_W'(reg_wdata_i);
        A_THI:  thi_q  <= CNT_W'(reg_wdata_i);
        A_ACT:  act_q  <= reg_wdata_i;
        A_RPT:  rpt_q  <= reg_wdata_i;
        A_LEN:  len_q  <= reg_wdata_i[7:4];
        A_GEN:  gen_q  <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  assign loc_pend = |(st_w & len_q);

  // global status re-arms from any pending enabled local bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gst_q <= 1'b0;
    else         gst_q <= loc_pend | (gst_q & ~gclr_w);
  end

  assign irq_o = gst_q & gen_q;

  bzm_window_acc #(
    .BEAT_W(BEAT_W), .UNIT_LG(UNIT_LG), .CNT_W(CNT_W), .WIN_W(WIN_W)
  ) acc_i (
    .clk_i, .rst_ni,
    .en_i(en_q), .clr_i(clr_cmd), .tick_i, .win_len_i(win_q),
    .beat_vld_i, .beat_bytes_i,
    .eval_o(eval_w), .win_cnt_o(win_cnt_w), .acc_o(acc_w)
  );

  bzm_zone_eval #(.CNT_W(CNT_W)) eval_i (
    .clk_i, .rst_ni,
    .eval_i(eval_w), .win_cnt_i(win_cnt_w),
    .thr_lo_i(tlo_q), .thr_mid_i(tmid_q), .thr_hi_i(thi_q),
    .act_i(act_q), .rpt_i(rpt_q), .clr_i(clr_cmd), .st_clr_i(lclr_w),
    .zone_o(zone_w), .evt_o(evt_w), .peak_o(peak_w), .status_o(st_w), .last_o(last_w)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL: reg_rdata_o = {31'd0, en_q};
      A_WIN:  reg_rdata_o = 32'(win_q);
      A_TLO:  reg_rdata_o = 32'(tlo_q);
      A_TMID: reg_rdata_o = 32'(tmid_q);
      A_THI:  reg_rdata_o = 32'(thi_q);
      A_ACT:  reg_rdata_o = act_q;
      A_RPT:  reg_rdata_o = rpt_q;
      A_LST:  reg_rdata_o = {24'd0, st_w, 4'd0};
      A_LEN:  reg_rdata_o = {24'd0, len_q, 4'd0};
      A_GST:  reg_rdata_o = {31'd0, gst_q};
      A_GEN:  reg_rdata_o = {31'd0, gen_q};
      A_LAST: reg_rdata_o = 32'(last_w);
      5'd16, 5'd17, 5'd18, 5'd19: reg_rdata_o = 32'(peak_w[reg_addr_i[1:0]]);
      5'd20, 5'd21, 5'd22, 5'd23: reg_rdata_o = 32'(evt_w[reg_addr_i[1:0]]);
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/bzm_checker.sv
module bzm_checker #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             eval_i,
  input logic [CNT_W-1:0] win_cnt_i,
  input logic [CNT_W-1:0] thr_hi_i,
  input logic [1:0]       zone_i,
  input logic             loc_pend_i,
  input logic             gst_i,
  input logic             clr_i,
  input logic [CNT_W-1:0] acc_i,
  input logic [3:0]       st_i,
  input logic [31:0]      rpt_i
);
  // R2
  eval_when_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i |-> en_i);

  // R3
  zone_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eval_i && win_cnt_i >= thr_hi_i) |-> zone_i == 2'd3);

  // R8
  glb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_pend_i |=> gst_i);

  // R10
  clr_acc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_i == '0);

  for (genvar z = 0; z < 4; z++) begin : g_mute
    // R6
    mute_zone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rpt_i[8*z +: 8] == 8'hFF && !st_i[z]) |=> !st_i[z]);
  end
endmodule

bind bw_zone_mon bzm_checker #(.CNT_W(CNT_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_q), .eval_i(eval_w),
  .win_cnt_i(win_cnt_w), .thr_hi_i(thi_q), .zone_i(zone_w),
  .loc_pend_i(loc_pend), .gst_i(gst_q), .clr_i(clr_cmd), .acc_i(acc_w),
  .st_i(st_w), .rpt_i(rpt_q)
);

// File: tb/bw_zone_mon_tb_top.sv
module bw_zone_mon_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        vld = 1'b0;
  logic [19:0] bytes = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;

  always #4 clk = ~clk;

  bw_zone_mon dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .beat_vld_i(vld),
    .beat_bytes_i(bytes), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic wr_reg(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd_reg(a, d);
    chk(req, d, exp);
  endtask

  task automatic beat(logic [19:0] b);
    @(negedge clk); vld = 1'b1; bytes = b;
    @(negedge clk); vld = 1'b0; bytes = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_units(int n);
    for (int i = 0; i < n; i++) beat(20'h10000);
    ticks(4);
  endtask

  task automatic t_reset;
    rd_chk("R5 actions default", 5'd6, 32'h95250901);
    rd_chk("R5 repeat default", 5'd7, 32'hFFFFFFFF);
    rd_chk("R11 local status", 5'd8, 32'h0);
    rd_chk("R11 global status", 5'd11, 32'h0);
    chk("R11 irq", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_config;
    wr_reg(5'd2, 32'd4);
    wr_reg(5'd3, 32'd2);
    wr_reg(5'd4, 32'd5);
    wr_reg(5'd5, 32'd8);
    wr_reg(5'd7, 32'h01FF02FF);
    wr_reg(5'd10, 32'hA0);
    wr_reg(5'd13, 32'h1);
    wr_reg(5'd0, 32'h1);
  endtask

  task automatic t_units;
    for (int i = 0; i < 3; i++) beat(20'h08000);
    ticks(4);
    rd_chk("R1 half units carry", 5'd14, 32'd1);
    beat(20'h08000);
    ticks(4);
    rd_chk("R1 remainder dropped at boundary", 5'd14, 32'd0);
  endtask

  task automatic t_zones;
    run_units(2);
    rd_chk("R3 equal low -> zone1", 5'd21, 32'd1);
    run_units(5);
    rd_chk("R3 equal mid -> zone2", 5'd22, 32'd1);
    rd_chk("R5 zone2 hit clears zone1", 5'd21, 32'd0);
    rd_chk("R6 zone1 below limit", 5'd8, 32'h0);
    run_units(8);
    rd_chk("R3 equal high -> zone3", 5'd23, 32'd1);
    rd_chk("R6 zone3 status", 5'd8, 32'h80);
    chk("R8 irq raised", {31'd0, irq}, 32'h1);
    wr_reg(5'd12, 32'h1);
    rd_chk("R8 global clear blocked while pending", 5'd11, 32'h1);
    wr_reg(5'd9, 32'h80);
    rd_chk("R7 local clear", 5'd8, 32'h0);
    wr_reg(5'd12, 32'h1);
    rd_chk("R8 global cleared", 5'd11, 32'h0);
    chk("R8 irq dropped", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_peaks;
    run_units(4);
    run_units(3);
    rd_chk("R9 zone1 peak", 5'd17, 32'd4);
    rd_chk("R9 zone2 peak", 5'd18, 32'd5);
    rd_chk("R9 zone3 peak", 5'd19, 32'd8);
    rd_chk("R6 zone1 reaches limit 2", 5'd8, 32'h20);
    chk("R8 irq zone1", {31'd0, irq}, 32'h1);
    wr_reg(5'd9, 32'h20);
    wr_reg(5'd12, 32'h1);
  endtask

  task automatic t_mute;
    run_units(5);
    rd_chk("R6 muted zone2", 5'd8, 32'h0);
    wr_reg(5'd7, 32'h010102FF);
    run_units(6);
    rd_chk("R7 status latches while disabled", 5'd8, 32'h40);
    chk("R7 no irq from disabled zone", {31'd0, irq}, 32'h0);
    wr_reg(5'd9, 32'h40);
  endtask

  task automatic t_actions;
    wr_reg(5'd1, 32'h1);
    wr_reg(5'd6, 32'h95250E01);
    run_units(2);
    rd_chk("R4 inc+clr gives 1", 5'd21, 32'd1);
    rd_chk("R4 inc other zone", 5'd20, 32'd1);
    run_units(2);
    rd_chk("R4 inc+clr stays 1", 5'd21, 32'd1);
    rd_chk("R4 second inc", 5'd20, 32'd2);
  endtask

  task automatic t_clear;
    wr_reg(5'd1, 32'h1);
    rd_chk("R10 counter cleared", 5'd20, 32'd0);
    rd_chk("R10 peak cleared", 5'd17, 32'd0);
    beat(20'h10000);
    beat(20'h10000);
    wr_reg(5'd1, 32'h1);
    ticks(4);
    rd_chk("R10 mid-window clear", 5'd14, 32'd0);
  endtask

  task automatic t_window;
    for (int i = 0; i < 3; i++) beat(20'h10000);
    ticks(3);
    rd_chk("R2 no close before W ticks", 5'd14, 32'd0);
    ticks(1);
    rd_chk("R2 close on W-th tick", 5'd14, 32'd3);
    wr_reg(5'd0, 32'h0);
    run_units(5);
    rd_chk("R2 disabled ignored", 5'd14, 32'd3);
    wr_reg(5'd0, 32'h1);
    run_units(1);
    rd_chk("R2 disabled beats not counted", 5'd14, 32'd1);
    wr_reg(5'd2, 32'd0);
    beat(20'h10000);
    beat(20'h10000);
    ticks(8);
    rd_chk("R2 zero length never closes", 5'd14, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_config();
    t_units();
    t_zones();
    t_peaks();
    t_mute();
    t_actions();
    t_clear();
    t_window();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule